// File: doc/BRIEF.md
# Scan Chain Test Controller

This block is a bank of flip-flops placed around a small combinational function. In normal operation the bank captures that function's next-state value on every clock. A multiplexer in front of each flop lets the bank also act as one serial shift path. Data enters at `scan_in`, moves one position toward bit 0 on each shift clock, and leaves at `scan_out`. This makes every state bit both settable and readable from two pins, so a test of the stored design reduces to a test of the combinational logic alone.

An internal sequencer runs one scan test when `start` arrives in test mode. It first shifts in a vector of W bits over W cycles. It then allows one functional capture cycle. Finally it shifts the captured response out over W cycles. During the unload, whatever is presented on `scan_in` fills the chain, so the next vector can be loaded at the same time as the response leaves. The placeholder logic is `func_in XOR rotate-left-by-one(state)`.

Top module: `scan_chain_ctrl`

## Requirements
- R1: After reset is asserted (active low), func_out is all zeros, and scan_out, busy and done are 0.
- R2: With test_mode low, on every clock func_out takes func_in XOR the old func_out rotated left by one: bit i receives func_in[i] ^ old bit i-1, and bit 0 receives func_in[0] ^ old bit W-1.
- R3: With test_mode high and no test running (busy low), func_out holds its value.
- R4: A start sampled high with test_mode high and busy low makes busy high on the next cycle. W shift cycles follow. On each of them, scan_in enters bit W-1 and every bit moves one place toward bit 0. The first bit shifted in ends at bit 0, and scan_out always shows bit 0.
- R5: After the W load shifts, exactly one capture cycle loads the bank with the combinational value of R2.
- R6: W unload shifts follow the capture. scan_out presents the response bit 0 first, then ascending bits. The scan_in bits applied during the unload fill the bank, with the first of them in bit 0.
- R7: busy is high for exactly 2W+1 consecutive cycles. done then pulses for exactly one cycle while busy is low, and done and busy are never high together.
- R8: A start pulse while busy is high is ignored, and the test length is unchanged.
- R9: Driving test_mode low aborts a running test. On the next cycle busy and done are low, and the bank has made a normal R2 capture.
- R10: A start while test_mode is low does not begin a test.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | Selects test operation; low gives normal capture |
| start | input | 1 | Begins one scan test when idle in test mode |
| scan_in | input | 1 | Serial data into the top of the chain |
| func_in | input | W | Parallel functional inputs to the combinational logic |
| func_out | output | W | Parallel state of the register bank |
| scan_out | output | 1 | Serial data from bit 0 of the chain |
| busy | output | 1 | High from load through the last unload bit |
| done | output | 1 | One-cycle pulse after a completed test |

## Verification
The bench builds the block with W = 5. This chain length is odd and not a power of two, so the shift counter starts from a value that is not its all-ones wrap point. An off-by-one in the counter's terminal test then changes the observable busy length and bit order. Five bits are few enough for every bit of each loaded vector, captured response and reloaded vector to be compared individually. A vector table covers several vector, function-input and reload patterns, and directed tests cover aborts and ignored starts.

// File: rtl/scan_chain_ctrl.sv
module scan_chain_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         test_mode,
  input  logic         start,
  input  logic         scan_in,
  input  logic [W-1:0] func_in,
  output logic [W-1:0] func_out,
  output logic         scan_out,
  output logic         busy,
  output logic         done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  typedef enum logic [2:0] {IDLE, SHIFT_IN, CAPTURE, SHIFT_OUT, DONE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [W-1:0]  q;
  logic [W-1:0]  comb;
  logic          shifting;

  assign comb     = func_in ^ {q[W-2:0], q[W-1]};
  assign shifting = (st == SHIFT_IN) || (st == SHIFT_OUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= IDLE;
      cnt <= '0;
    end else if (!test_mode) begin
      st  <= IDLE;
      cnt <= '0;
    end else begin
      case (st)
        IDLE, DONE: begin
          if (start) begin
            st  <= SHIFT_IN;
            cnt <= LAST;
          end else begin
            st  <= IDLE;
          end
        end
        SHIFT_IN: begin
          if (cnt == '0) st <= CAPTURE;
          else           cnt <= cnt - 1'b1;
        end
        CAPTURE: begin
          st  <= SHIFT_OUT;
          cnt <= LAST;
        end
        SHIFT_OUT: begin
          if (cnt == '0) st <= DONE;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              q <= '0;
    else if (!test_mode)     q <= comb;
    else if (shifting)       q <= {scan_in, q[W-1:1]};
    else if (st == CAPTURE)  q <= comb;
  end

  assign func_out = q;
  assign scan_out = q[0];
  assign busy     = (st == SHIFT_IN) || (st == CAPTURE) || (st == SHIFT_OUT);
  assign done     = (st == DONE);
endmodule

module scan_chain_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         test_mode,
  input logic         start,
  input logic [W-1:0] func_out,
  input logic         busy,
  input logic         done
);
  // R7
  excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(busy));

  // R4
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && start && !busy) |=> busy);

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |=> (!busy && !done));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !busy) |=> (func_out == $past(func_out)));
endmodule

bind scan_chain_ctrl scan_chain_ctrl_chk #(.W(W)) u_chk (.*);

// File: tb/test_scan_chain_ctrl.sv
module test_scan_chain_ctrl;
  localparam int W = 5;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  localparam logic [W-1:0] VIN [NV] = '{5'h15, 5'h0A, 5'h1F, 5'h00, 5'h13, 5'h01};
  localparam logic [W-1:0] FIN [NV] = '{5'h00, 5'h1F, 5'h05, 5'h12, 5'h0C, 5'h10};
  localparam logic [W-1:0] NXT [NV] = '{5'h0E, 5'h11, 5'h00, 5'h1F, 5'h06, 5'h18};

  logic clk = 0, rst_n = 0, test_mode = 0, start = 0, scan_in = 0;
  logic [W-1:0] func_in = '0;
  logic [W-1:0] func_out;
  logic scan_out, busy, done;
  int n_tests = 0, n_fail = 0;

  scan_chain_ctrl #(.W(W)) i_scan_chain_ctrl (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .start(start), .scan_in(scan_in),
    .func_in(func_in), .func_out(func_out), .scan_out(scan_out), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [W-1:0] nxt_val(logic [W-1:0] fi, logic [W-1:0] st);
    return fi ^ {st[W-2:0], st[W-1]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_test(input logic [W-1:0] vin, input logic [W-1:0] fin,
                          input logic [W-1:0] nx, input bit poke_start);
    logic [W-1:0] resp, got;
    int busy_cnt;
    busy_cnt = 0;
    resp = nxt_val(fin, vin);
    got = '0;
    func_in = fin;
    test_mode = 1;
    start = 1;
    step();
    start = 0;
    chk(busy == 1'b1, "R4 busy after start", busy, 1);
    for (int k = 0; k < W; k++) begin
      if (busy) busy_cnt++;
      chk(scan_out == func_out[0], "R4 scan_out tracks bit0", scan_out, func_out[0]);
      scan_in = vin[k];
      start = poke_start && (k == 1);
      step();
    end
    start = 0;
    chk(func_out == vin, "R4 loaded vector", func_out, vin);
    if (busy) busy_cnt++;
    step();
    chk(func_out == resp, "R5 captured response", func_out, resp);
    for (int k = 0; k < W; k++) begin
      if (busy) busy_cnt++;
      got[k] = scan_out;
      scan_in = nx[k];
      step();
    end
    chk(got == resp, "R6 unloaded response order", got, resp);
    chk(func_out == nx, "R6 reloaded vector", func_out, nx);
    chk(busy_cnt == 2 * W + 1, poke_start ? "R8 length with extra start" : "R7 busy length",
        busy_cnt, 2 * W + 1);
    chk(done == 1'b1 && busy == 1'b0, "R7 done pulse", {busy, done}, 2'b01);
    step();
    chk(done == 1'b0 && busy == 1'b0, "R7 done single cycle", {busy, done}, 2'b00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] exp_q;
    repeat (2) @(negedge clk);
    chk(func_out == '0 && !busy && !done && !scan_out, "R1 reset state",
        {func_out, scan_out, busy, done}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 normal capture under several input patterns
    exp_q = func_out;
    for (int i = 0; i < 6; i++) begin
      func_in = 5'(i * 7 + 3);
      exp_q = nxt_val(func_in, exp_q);
      step();
      chk(func_out == exp_q, "R2 normal capture", func_out, exp_q);
    end

    // R3 hold in idle test mode
    test_mode = 1;
    func_in = 5'h1B;
    exp_q = func_out;
    repeat (3) step();
    chk(func_out == exp_q && !busy, "R3 idle hold", func_out, exp_q);

    // table of scan tests
    for (int i = 0; i < NV; i++) run_test(VIN[i], FIN[i], NXT[i], 1'b0);

    // R8 start during busy
    run_test(5'h0B, 5'h06, 5'h14, 1'b1);

    // R9 abort mid-load
    test_mode = 1;
    start = 1;
    step();
    start = 0;
    scan_in = 1;
    step();
    step();
    func_in = 5'h09;
    exp_q = nxt_val(func_in, func_out);
    test_mode = 0;
    step();
    chk(!busy && !done, "R9 abort flags", {busy, done}, 0);
    chk(func_out == exp_q, "R9 abort capture", func_out, exp_q);

    // R10 start ignored in normal mode
    start = 1;
    step();
    start = 0;
    chk(!busy, "R10 start ignored", busy, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule